// File: doc/BRIEF.md
# Sampled-Frame Release Scheduler

This block decides when each outgoing sampled-value frame leaves. A frame is named by its index within the current second. The block splits that index into a millisecond slot and a tick offset inside the slot. It can shift that time by a small signed dispersion. It then raises a one-cycle release strobe when its own free-running timebase reaches the computed time.

Configuration is loaded once, while the block is idle. It sets the frame rate per second, the timebase ticks per second and a dispersion magnitude in microseconds. The block derives the per-slot and per-frame constants from these with one shared sequential divider. After that, each frame request takes one divide, one multiply and a borrow/carry adjustment. The block then waits for the matching timebase instant. The random value that picks the dispersion sign comes from outside the block. Only its parity matters.

Top module: `sample_send_sched`

## Requirements
- R1: While reset is held and right after it, `busy_o`, `cfg_ok_o` and `send_o` are 0, and the timebase outputs `tb_ms_o` and `tb_tick_o` are 0.
- R2: A configuration load clears the timebase, and the timebase stays at 0 until `cfg_ok_o` rises. After that, `tb_tick_o` advances by one every clock and wraps after tps/1000 − 1. Each wrap increments `tb_ms_o`, which wraps from 999 to 0.
- R3: Without dispersion, the release slot `seq_o` is n / (rate/1000), where n is `frame_idx_i` and the division truncates.
- R4: Without dispersion, the release offset `off_o` is (n mod (rate/1000)) × (tps / rate) ticks.
- R5: The dispersion is min(`cfg_disp_i`, 10) × tps / 1,000,000 ticks, truncated. A value of `cfg_disp_i` above 10 acts as 10. Dispersion is applied only when `disp_en_i` is 1 with the request.
- R6: The dispersion sign comes from bit 0 of `rand_i`. A value of 1 (odd) subtracts the dispersion from the offset, and 0 (even) adds it.
- R7: If subtraction would make the offset negative, the release moves to the previous slot (slot 0 becomes 999), and the offset becomes offset + tps/1000 − dispersion.
- R8: If addition reaches tps/1000 or more, the release moves to the next slot (999 becomes 0), and the offset drops by tps/1000.
- R9: `send_o` is high for exactly one cycle, in the cycle when `tb_ms_o` equals `seq_o` and `tb_tick_o` equals `off_o`. `seq_o` and `off_o` hold the adjusted target until release.
- R10: A frame request is ignored before the first configuration completes and while the block is busy. It leaves the pending target and the release unchanged.
- R11: `busy_o` is high from the cycle after an accepted request up to and including the release cycle, and is low in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one timebase tick per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Load configuration (taken only when idle) |
| cfg_rate_i | input | CW | Frames per second, a multiple of 1000 |
| cfg_tps_i | input | CW | Timebase ticks per second |
| cfg_disp_i | input | MGW | Dispersion magnitude in microseconds |
| frame_req_i | input | 1 | Request scheduling of one frame |
| frame_idx_i | input | NW | Frame index within the second, below the rate |
| disp_en_i | input | 1 | Apply dispersion to this frame |
| rand_i | input | RW | Random value; its parity selects the sign |
| busy_o | output | 1 | Configuring, computing or waiting to release |
| cfg_ok_o | output | 1 | Configuration valid, timebase running |
| send_o | output | 1 | One-cycle release strobe |
| seq_o | output | 10 | Target millisecond slot |
| off_o | output | CW | Target tick offset inside the slot |
| tb_ms_o | output | 10 | Timebase millisecond count |
| tb_tick_o | output | CW | Timebase tick count inside the millisecond |

## Verification
The bound checks watch every cycle for the following:
- the strobe lasts one cycle;
- the strobe occurs only at the exact timebase match, while busy and configured;
- the released offset stays inside its slot;
- the tick counter steps by one;
- the millisecond counter stays below 1000 and wraps only from 999.

Whether the slot and offset come out right for a given index, rate, dispersion setting and sign needs the bench's scenarios. The same holds for saturation of the magnitude and for borrow into slot 999 at the start of a second. The bench compares each release against a reference model.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int unsigned MS_PER_S = 1000;
  localparam int unsigned US_PER_S = 1000000;
  localparam int unsigned DISP_MAX = 10;
  localparam int unsigned MSW      = 10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TPMS,
    ST_FPM,
    ST_TPF,
    ST_DISP,
    ST_SEQ,
    ST_ADJ,
    ST_ARMED
  } sched_st_e;
endpackage

// File: rtl/sched_div.sv
// Restoring divider, one quotient bit per cycle; done_o pulses when results are valid.
module sched_div #(
  parameter int unsigned W = 36
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int unsigned CNTW = $clog2(W + 1);

  logic [W-1:0]    quo_q, rem_q, den_q;
  logic [CNTW-1:0] cnt_q;
  logic            run_q, done_q;
  logic [W:0]      shifted, diff;
  logic            ge;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    ge      = shifted >= {1'b0, den_q};
    diff    = shifted - {1'b0, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      quo_q  <= num_i;
      rem_q  <= '0;
      den_q  <= den_i;
      cnt_q  <= CNTW'(W);
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (run_q) begin
      quo_q <= {quo_q[W-2:0], ge};
      rem_q <= ge ? diff[W-1:0] : shifted[W-1:0];
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNTW'(1)) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/sched_timebase.sv
module sched_timebase import sched_pkg::*; #(
  parameter int unsigned CW = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           en_i,
  input  logic [CW-1:0]  tpms_i,
  output logic [MSW-1:0] ms_o,
  output logic [CW-1:0]  tick_o
);
  logic [MSW-1:0] ms_q;
  logic [CW-1:0]  tick_q;
  logic           last_tick, last_ms;

  assign last_tick = tick_q == (tpms_i - 1'b1);
  assign last_ms   = ms_q == MSW'(MS_PER_S - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ms_q   <= '0;
      tick_q <= '0;
    end else if (clr_i) begin
      ms_q   <= '0;
      tick_q <= '0;
    end else if (en_i) begin
      if (last_tick) begin
        tick_q <= '0;
        ms_q   <= last_ms ? '0 : ms_q + 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign ms_o   = ms_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/sched_adjust.sv
// Applies the signed dispersion with borrow/carry across millisecond slots.
module sched_adjust import sched_pkg::*; #(
  parameter int unsigned CW = 32
) (
  input  logic [MSW-1:0] seq_i,
  input  logic [CW-1:0]  off_i,
  input  logic [CW-1:0]  dtk_i,
  input  logic [CW-1:0]  tpms_i,
  input  logic           en_i,
  input  logic           neg_i,
  output logic [MSW-1:0] seq_o,
  output logic [CW-1:0]  off_o
);
  logic [CW:0]    up_sum, dn_wrap;
  logic [MSW-1:0] seq_prev, seq_next;

  always_comb begin
    seq_prev = (seq_i == '0) ? MSW'(MS_PER_S - 1) : seq_i - 1'b1;
    seq_next = (seq_i >= MSW'(MS_PER_S - 1)) ? '0 : seq_i + 1'b1;
    up_sum   = {1'b0, off_i} + {1'b0, dtk_i};
    dn_wrap  = {1'b0, off_i} + {1'b0, tpms_i} - {1'b0, dtk_i};
    seq_o    = seq_i;
    off_o    = off_i;
    if (en_i && dtk_i != '0) begin
      if (neg_i) begin
        if (off_i >= dtk_i) begin
          off_o = off_i - dtk_i;
        end else begin
          seq_o = seq_prev;
          off_o = dn_wrap[CW-1:0];
        end
      end else if (up_sum >= {1'b0, tpms_i}) begin
        seq_o = seq_next;
        off_o = CW'(up_sum - {1'b0, tpms_i});
      end else begin
        off_o = up_sum[CW-1:0];
      end
    end
  end
endmodule

// File: rtl/sample_send_sched.sv
module sample_send_sched import sched_pkg::*; #(
  parameter int unsigned CW  = 32,
  parameter int unsigned NW  = 16,
  parameter int unsigned RW  = 8,
  parameter int unsigned MGW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_load_i,
  input  logic [CW-1:0]  cfg_rate_i,
  input  logic [CW-1:0]  cfg_tps_i,
  input  logic [MGW-1:0] cfg_disp_i,
  input  logic           frame_req_i,
  input  logic [NW-1:0]  frame_idx_i,
  input  logic           disp_en_i,
  input  logic [RW-1:0]  rand_i,
  output logic           busy_o,
  output logic           cfg_ok_o,
  output logic           send_o,
  output logic [MSW-1:0] seq_o,
  output logic [CW-1:0]  off_o,
  output logic [MSW-1:0] tb_ms_o,
  output logic [CW-1:0]  tb_tick_o
);
  localparam int unsigned DW = CW + MGW;

  sched_st_e      st_q;
  logic           go_q, cfg_ok_q, tb_clr_q;
  logic [CW-1:0]  rate_q, tps_q, tpms_q, fpm_q, tpf_q, dtk_q;
  logic [MGW-1:0] mag_q;
  logic [NW-1:0]  idx_q;
  logic           en_q, neg_q;
  logic [MSW-1:0] seq_q;
  logic [CW-1:0]  off_q;

  logic [DW-1:0]  div_num, div_den, div_quo, div_rem;
  logic           div_done;
  logic [MSW-1:0] seq_raw, seq_adj, tb_ms;
  logic [CW-1:0]  off_raw, off_adj, tb_tick;
  logic           hit;
  logic           unused_rand;

  assign unused_rand = ^rand_i[RW-1:1];

  always_comb begin
    div_num = '0;
    div_den = DW'(1);
    case (st_q)
      ST_TPMS: begin div_num = DW'(tps_q);  div_den = DW'(MS_PER_S); end
      ST_FPM:  begin div_num = DW'(rate_q); div_den = DW'(MS_PER_S); end
      ST_TPF:  begin div_num = DW'(tps_q);  div_den = DW'(rate_q);   end
      ST_DISP: begin div_num = DW'(mag_q) * DW'(tps_q); div_den = DW'(US_PER_S); end
      ST_SEQ:  begin div_num = DW'(idx_q);  div_den = DW'(fpm_q);    end
      default: ;
    endcase
  end

  sched_div #(.W(DW)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (go_q),
    .num_i   (div_num),
    .den_i   (div_den),
    .done_o  (div_done),
    .quo_o   (div_quo),
    .rem_o   (div_rem)
  );

  assign seq_raw = MSW'(div_quo);
  assign off_raw = CW'(div_rem * DW'(tpf_q));

  sched_adjust #(.CW(CW)) u_adj (
    .seq_i  (seq_raw),
    .off_i  (off_raw),
    .dtk_i  (dtk_q),
    .tpms_i (tpms_q),
    .en_i   (en_q),
    .neg_i  (neg_q),
    .seq_o  (seq_adj),
    .off_o  (off_adj)
  );

  sched_timebase #(.CW(CW)) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tb_clr_q),
    .en_i   (cfg_ok_q),
    .tpms_i (tpms_q),
    .ms_o   (tb_ms),
    .tick_o (tb_tick)
  );

  assign hit = (st_q == ST_ARMED) && (tb_ms == seq_q) && (tb_tick == off_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      go_q     <= 1'b0;
      cfg_ok_q <= 1'b0;
      tb_clr_q <= 1'b0;
      rate_q   <= '0;
      tps_q    <= '0;
      mag_q    <= '0;
      tpms_q   <= '0;
      fpm_q    <= '0;
      tpf_q    <= '0;
      dtk_q    <= '0;
      idx_q    <= '0;
      en_q     <= 1'b0;
      neg_q    <= 1'b0;
      seq_q    <= '0;
      off_q    <= '0;
    end else begin
      go_q     <= 1'b0;
      tb_clr_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (cfg_load_i) begin
            rate_q   <= cfg_rate_i;
            tps_q    <= cfg_tps_i;
            mag_q    <= (cfg_disp_i > MGW'(DISP_MAX)) ? MGW'(DISP_MAX) : cfg_disp_i;
            cfg_ok_q <= 1'b0;
            tb_clr_q <= 1'b1;
            go_q     <= 1'b1;
            st_q     <= ST_TPMS;
          end else if (frame_req_i && cfg_ok_q) begin
            idx_q <= frame_idx_i;
            en_q  <= disp_en_i;
            neg_q <= rand_i[0];
            go_q  <= 1'b1;
            st_q  <= ST_SEQ;
          end
        end
        ST_TPMS: if (div_done) begin
          tpms_q <= CW'(div_quo);
          go_q   <= 1'b1;
          st_q   <= ST_FPM;
        end
        ST_FPM: if (div_done) begin
          fpm_q <= CW'(div_quo);
          go_q  <= 1'b1;
          st_q  <= ST_TPF;
        end
        ST_TPF: if (div_done) begin
          tpf_q <= CW'(div_quo);
          go_q  <= 1'b1;
          st_q  <= ST_DISP;
        end
        ST_DISP: if (div_done) begin
          dtk_q    <= CW'(div_quo);
          cfg_ok_q <= 1'b1;
          st_q     <= ST_IDLE;
        end
        ST_SEQ: if (div_done) st_q <= ST_ADJ;
        ST_ADJ: begin
          seq_q <= seq_adj;
          off_q <= off_adj;
          st_q  <= ST_ARMED;
        end
        ST_ARMED: if (hit) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = st_q != ST_IDLE;
  assign cfg_ok_o  = cfg_ok_q;
  assign send_o    = hit;
  assign seq_o     = seq_q;
  assign off_o     = off_q;
  assign tb_ms_o   = tb_ms;
  assign tb_tick_o = tb_tick;
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
  parameter int unsigned CW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          send_o,
  input logic          busy_o,
  input logic          cfg_ok_o,
  input logic [9:0]    seq_o,
  input logic [CW-1:0] off_o,
  input logic [9:0]    tb_ms_o,
  input logic [CW-1:0] tb_tick_o,
  input logic [CW-1:0] tpms_i
);
  assert_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_o |=> !send_o);

  assert_release_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_o |-> (tb_ms_o == seq_o && tb_tick_o == off_o));

  assert_ms_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tb_ms_o < 10'd1000);

  assert_tick_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_ok_o) && cfg_ok_o && tb_tick_o != '0) |-> tb_tick_o == $past(tb_tick_o) + 1'b1);

  assert_ms_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_ok_o) && tb_ms_o == '0 && $past(tb_ms_o) != '0) |-> $past(tb_ms_o) == 10'd999);

  assert_off_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_o |-> off_o < tpms_i);

  assert_send_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_o |-> busy_o);

  assert_cfg_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_o |-> cfg_ok_o);
endmodule

bind sample_send_sched sched_chk #(.CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .send_o    (send_o),
  .busy_o    (busy_o),
  .cfg_ok_o  (cfg_ok_o),
  .seq_o     (seq_o),
  .off_o     (off_o),
  .tb_ms_o   (tb_ms_o),
  .tb_tick_o (tb_tick_o),
  .tpms_i    (tpms_q)
);

// File: tb/tb_sample_send_sched.sv
module tb_sample_send_sched;
  localparam int CW = 32, NW = 16, RW = 8, MGW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic           cfg_load = 1'b0;
  logic [CW-1:0]  cfg_rate = '0, cfg_tps = '0;
  logic [MGW-1:0] cfg_disp = '0;
  logic           frame_req = 1'b0;
  logic [NW-1:0]  frame_idx = '0;
  logic           disp_en = 1'b0;
  logic [RW-1:0]  rnd = '0;
  logic           busy, cfg_ok, send;
  logic [9:0]     seq, tb_ms;
  logic [CW-1:0]  off, tb_tick;

  sample_send_sched #(.CW(CW), .NW(NW), .RW(RW), .MGW(MGW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .cfg_rate_i(cfg_rate),
    .cfg_tps_i(cfg_tps), .cfg_disp_i(cfg_disp), .frame_req_i(frame_req),
    .frame_idx_i(frame_idx), .disp_en_i(disp_en), .rand_i(rnd), .busy_o(busy),
    .cfg_ok_o(cfg_ok), .send_o(send), .seq_o(seq), .off_o(off),
    .tb_ms_o(tb_ms), .tb_tick_o(tb_tick)
  );

  int errs = 0, checks = 0;
  longint m_tps, m_rate, m_mag;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk("watchdog", 1, 0);
    summary();
  end

  // Reference model for R3..R8
  task automatic model(input longint n, input bit en, input bit odd,
                       output longint s, output longint o);
    longint fpm, t, tpms, m, d;
    fpm  = m_rate / 1000;
    t    = m_tps / m_rate;
    tpms = m_tps / 1000;
    m    = (m_mag > 10) ? 10 : m_mag;
    d    = m * m_tps / 1000000;
    s    = n / fpm;
    o    = (n % fpm) * t;
    if (en && d != 0) begin
      if (odd) begin
        if (o >= d) o = o - d;
        else begin o = o + tpms - d; s = (s + 999) % 1000; end
      end else begin
        o = o + d;
        if (o >= tpms) begin o = o - tpms; s = (s + 1) % 1000; end
      end
    end
  endtask

  task automatic do_cfg(input longint tps, input longint rate, input int mag);
    m_tps = tps; m_rate = rate; m_mag = mag;
    @(negedge clk);
    cfg_load = 1'b1; cfg_tps = CW'(tps); cfg_rate = CW'(rate); cfg_disp = MGW'(mag);
    @(negedge clk);
    cfg_load = 1'b0;
    for (int i = 0; i < 400 && !cfg_ok; i++) @(negedge clk);
    chk("R2 cfg_ok after load", longint'(cfg_ok), 1);
    chk("R2 timebase ms restarts at 0", longint'(tb_ms), 0);
    chk("R2 timebase tick restarts at 0", longint'(tb_tick), 0);
  endtask

  task automatic run_frame(input string tag, input longint n, input bit en,
                           input logic [RW-1:0] r, input bit inject, input int tmo);
    longint es, eo;
    bit seen;
    model(n, en, r[0], es, eo);
    frame_req = 1'b1; frame_idx = NW'(n); disp_en = en; rnd = r;
    @(negedge clk);
    frame_req = 1'b0;
    chk("R11 busy after request", longint'(busy), 1);
    if (inject) begin
      repeat (60) @(negedge clk);
      frame_req = 1'b1; frame_idx = NW'(n + 3); disp_en = ~en; rnd = ~r;
      @(negedge clk);
      frame_req = 1'b0;
    end
    seen = 1'b0;
    for (int i = 0; i < tmo; i++) begin
      if (send) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk({"R9 release seen ", tag}, longint'(seen), 1);
    chk({"slot ", tag}, longint'(seq), es);
    chk({"offset ", tag}, longint'(off), eo);
    chk("R9 tb ms at release", longint'(tb_ms), es);
    chk("R9 tb tick at release", longint'(tb_tick), eo);
    @(negedge clk);
    chk("R9 strobe one cycle", longint'(send), 0);
    chk("R11 idle after release", longint'(busy), 0);
  endtask

  // picks a slot comfortably ahead of the running timebase (phase 1: 200 frames/ms)
  function automatic longint base_slot();
    return (tb_tick < 900) ? longint'(tb_ms) + 1 : longint'(tb_ms) + 2;
  endfunction

  initial begin
    longint ms0, tk0;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", longint'(busy), 0);
    chk("R1 cfg_ok in reset", longint'(cfg_ok), 0);
    chk("R1 send in reset", longint'(send), 0);
    chk("R1 tb_ms in reset", longint'(tb_ms), 0);
    chk("R1 tb_tick in reset", longint'(tb_tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", longint'(busy), 0);

    // R10: request before configuration is ignored
    frame_req = 1'b1; frame_idx = 16'd4;
    @(negedge clk);
    frame_req = 1'b0;
    chk("R10 request before config ignored", longint'(busy), 0);
    repeat (5) @(negedge clk);
    chk("R10 no release before config", longint'(send), 0);

    // Phase 1: 1 MHz ticks, 200 frames/ms, t=5, magnitude 13 saturates to 10 ticks (R5)
    do_cfg(1000000, 200000, 13);
    ms0 = tb_ms; tk0 = tb_tick;
    @(negedge clk);
    chk("R2 tick step", longint'(tb_tick), tk0 + 1);
    while (tb_tick != 999) @(negedge clk);
    ms0 = tb_ms;
    @(negedge clk);
    chk("R2 tick wraps at tps/1000", longint'(tb_tick), 0);
    chk("R2 ms increments on wrap", longint'(tb_ms), ms0 + 1);

    run_frame("R3 R4 plain", base_slot() * 200 + 7, 1'b0, 8'h01, 1'b0, 4000);
    run_frame("R5 disabled odd", base_slot() * 200 + 5, 1'b0, 8'h03, 1'b0, 4000);
    run_frame("R7 borrow at 0", base_slot() * 200 + 0, 1'b1, 8'h01, 1'b0, 4000);
    run_frame("R7 borrow at 1", base_slot() * 200 + 1, 1'b1, 8'h05, 1'b0, 4000);
    run_frame("R8 carry", base_slot() * 200 + 199, 1'b1, 8'h02, 1'b0, 4000);
    run_frame("R6 negative odd", base_slot() * 200 + 199, 1'b1, 8'h07, 1'b0, 4000);
    run_frame("R6 positive even", base_slot() * 200 + 3, 1'b1, 8'h10, 1'b0, 4000);
    run_frame("R5 saturated", base_slot() * 200 + 100, 1'b1, 8'h00, 1'b0, 4000);
    run_frame("R10 ignored while busy", base_slot() * 200 + 50, 1'b1, 8'h00, 1'b1, 4000);

    for (int k = 0; k < 16; k++) begin
      longint r;
      bit e, inj;
      logic [RW-1:0] rv;
      r   = longint'($urandom_range(199, 0));
      e   = 1'($urandom);
      rv  = RW'($urandom);
      inj = (k % 4) == 1;
      run_frame("R3 R4 R6 random", base_slot() * 200 + r, e, rv, inj, 4000);
    end

    // Phase 2: 100 ticks/ms, 1 frame/ms, dispersion 1 tick; slot 0 borrows into 999 (R7)
    do_cfg(100000, 1000, 10);
    run_frame("R7 borrow wraps to 999", 0, 1'b1, 8'h0b, 1'b0, 110000);

    summary();
  end
endmodule